// File: doc/BRIEF.md
# Frame-Based Receive Gain Control

This block scales a stream of complex baseband samples (16-bit signed I and Q) by a signed power of two and adjusts that scale on its own, once per frame. It sits between a digital down-converter and the range processing of a receiver. Samples enter and leave through a valid/ready pair. A frame-boundary strobe from the timing logic marks where one frame ends and the next begins.

During a frame the block records the largest output magnitude and counts the samples that clipped after scaling. At each boundary it captures those figures for reporting. If the frame was too loud, it lowers the gain by a programmable attack step and starts a holdoff period, counted in frames. Once the holdoff has run out and a frame stays below the target level, it raises the gain by a programmable decay step. Configuration arrives as plain level inputs. A packed status word gives the current gain, the captured peak, the captured clip count and the enable bit.

Stream rules: the input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result waits in the output register, unchanged, for as long as `out_valid` is high and `out_ready` is low. Each accepted sample appears on the outputs one cycle after acceptance. The frame strobe is never back-pressured.

Top module: `agc_frame_gain`

## Requirements
- R1: The gain is a 4-bit two's-complement value that stays within -7..+7. It is reported in status bits [3:0], and after reset it is 0.
- R2: A positive gain g shifts each lane left by g bits. A negative gain shifts it right arithmetically by |g| bits, keeping the sign, so -1000 at gain -4 gives -63 and 1000 gives 62.
- R3: A scaled lane beyond the 16-bit signed range clamps to +32767 or -32768. A sample counts once in the frame clip count if either lane clamped. The count saturates at 255 and is reported in status bits [27:20].
- R4: The frame peak is the largest max(|I|,|Q|) of the scaled outputs, with |-32768| taken as 32767. At each boundary the peak and clip count are captured into status bits [19:4] and [27:20], and these fields change at no other time.
- R5: A sample accepted in the same cycle as the frame strobe belongs to the frame that is ending, and it is included in that frame's captured peak and clip count.
- R6: At an enabled boundary, if the ending frame clipped or its peak exceeded the target, the gain drops by the attack step. The result is floored at -7, and the holdoff counter reloads with the holdoff setting.
- R7: At an enabled boundary that is not an attack, a nonzero holdoff counter decrements and the gain is held. When the counter is zero and the peak is below the target, the gain rises by the decay step, capped at +7. When the peak equals the target, nothing changes.
- R8: While enable is low, the gain and holdoff hold their values. Statistics are still captured, and status bit [28] mirrors the enable input.
- R9: `sat_flag` is high from the cycle after the first clip of a frame until the next boundary, and it is low in the cycle after every boundary.
- R10: Accepted samples appear on `out_i`/`out_q` with `out_valid` one cycle later. Under back-pressure the output holds steady and `in_ready` is low.
- R11: Reset clears the gain, holdoff, statistics, captured status and `sat_flag`, and leaves the output register empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample will be taken this cycle |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| frame_tick | input | 1 | One-cycle frame boundary strobe |
| cfg_enable | input | 1 | Automatic gain update enable |
| cfg_target | input | 16 | Target peak magnitude |
| cfg_attack | input | 4 | Gain decrease step, unsigned |
| cfg_decay | input | 4 | Gain increase step, unsigned |
| cfg_holdoff | input | 8 | Frames to wait after an attack before recovery |
| out_valid | output | 1 | Scaled sample present |
| out_ready | input | 1 | Downstream accepts the scaled sample |
| out_i | output | 16 | Scaled in-phase sample, signed |
| out_q | output | 16 | Scaled quadrature sample, signed |
| sat_flag | output | 1 | Current frame has clipped |
| status_word | output | 29 | {enable, clip count, peak, gain} |

## Verification
A wrong gain register shows up on the very next scaled sample as a wrong shift. In the status word it shows at the boundary that updated it. A wrong holdoff count stays hidden until the frame where recovery should or should not begin, so the tests step through boundaries one at a time and check the gain after each one. Errors in the peak or clip accumulators appear in the status word only at the next boundary. An error in the boundary-inclusion rule shows only when a sample coincides with the strobe, so that case is driven on purpose.

// File: rtl/agc_pkg.sv
package agc_pkg;
  // Decision taken by the gain controller at a frame boundary.
  typedef enum logic [1:0] {
    AGC_KEEP    = 2'd0,
    AGC_CUT     = 2'd1,
    AGC_WAIT    = 2'd2,
    AGC_RECOVER = 2'd3
  } agc_act_e;
endpackage

// File: rtl/agc_lane_scale.sv
module agc_lane_scale #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 4
) (
  input  logic [DATA_W-1:0] din,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] dout,
  output logic              clip,
  output logic [DATA_W-1:0] mag
);
  localparam int GMAX  = (1 << (GAIN_W - 1)) - 1;
  localparam int EXT_W = DATA_W + GMAX + 1;
  localparam logic signed [EXT_W-1:0] TOP = {{(EXT_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] BOT = ~TOP;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] shifted;
  logic [GAIN_W-1:0]       amt;

  always_comb begin
    // widen by replicating the sign bit, never by zero fill
    ext     = {{(EXT_W-DATA_W){din[DATA_W-1]}}, din};
    amt     = gain[GAIN_W-1] ? (~gain + GAIN_W'(1)) : gain;
    shifted = gain[GAIN_W-1] ? (ext >>> amt) : (ext <<< amt);
    if (shifted > TOP) begin
      dout = TOP[DATA_W-1:0];
      clip = 1'b1;
    end else if (shifted < BOT) begin
      dout = BOT[DATA_W-1:0];
      clip = 1'b1;
    end else begin
      dout = shifted[DATA_W-1:0];
      clip = 1'b0;
    end
    if (!dout[DATA_W-1])       mag = dout;
    else if (dout == MOST_NEG) mag = ~MOST_NEG;
    else                       mag = ~dout + DATA_W'(1);
  end
endmodule

// File: rtl/agc_frame_stats.sv
module agc_frame_stats #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_ok,
  input  logic [DATA_W-1:0] sample_mag,
  input  logic              sample_clip,
  input  logic              frame_tick,
  output logic [DATA_W-1:0] peak_incl,
  output logic [CNT_W-1:0]  clip_incl,
  output logic [DATA_W-1:0] frame_peak,
  output logic [CNT_W-1:0]  frame_clips,
  output logic              clip_seen
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] peak_acc;
  logic [CNT_W-1:0]  clip_acc;

  // running values that already include this cycle's sample
  always_comb begin
    peak_incl = (sample_ok && sample_mag > peak_acc) ? sample_mag : peak_acc;
    clip_incl = (sample_ok && sample_clip && clip_acc != CNT_MAX) ?
                clip_acc + CNT_W'(1) : clip_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_acc    <= '0;
      clip_acc    <= '0;
      frame_peak  <= '0;
      frame_clips <= '0;
    end else if (frame_tick) begin
      peak_acc    <= '0;
      clip_acc    <= '0;
      frame_peak  <= peak_incl;
      frame_clips <= clip_incl;
    end else begin
      peak_acc <= peak_incl;
      clip_acc <= clip_incl;
    end
  end

  assign clip_seen = (clip_acc != '0);
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 4,
  parameter int CNT_W  = 8,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              enable,
  input  logic [DATA_W-1:0] target,
  input  logic [GAIN_W-1:0] attack,
  input  logic [GAIN_W-1:0] decay,
  input  logic [HOLD_W-1:0] holdoff,
  input  logic [DATA_W-1:0] peak_incl,
  input  logic [CNT_W-1:0]  clip_incl,
  output logic [GAIN_W-1:0] gain
);
  localparam int WIDE_W = GAIN_W + 2;
  localparam int GMAX   = (1 << (GAIN_W - 1)) - 1;
  localparam logic signed [WIDE_W-1:0] HI = WIDE_W'(GMAX);
  localparam logic signed [WIDE_W-1:0] LO = -HI;

  logic [HOLD_W-1:0]       hold_left;
  agc_act_e                act;
  logic signed [WIDE_W-1:0] g_wide, g_down, g_up;
  logic [GAIN_W-1:0]       gain_down, gain_up;

  always_comb begin
    if (clip_incl != '0 || peak_incl > target) act = AGC_CUT;
    else if (hold_left != '0)                  act = AGC_WAIT;
    else if (peak_incl < target)               act = AGC_RECOVER;
    else                                       act = AGC_KEEP;
  end

  always_comb begin
    g_wide    = {{2{gain[GAIN_W-1]}}, gain};
    g_down    = g_wide - $signed({2'b00, attack});
    g_up      = g_wide + $signed({2'b00, decay});
    gain_down = (g_down < LO) ? LO[GAIN_W-1:0] : g_down[GAIN_W-1:0];
    gain_up   = (g_up > HI)   ? HI[GAIN_W-1:0] : g_up[GAIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain      <= '0;
      hold_left <= '0;
    end else if (frame_tick && enable) begin
      unique case (act)
        AGC_CUT: begin
          gain      <= gain_down;
          hold_left <= holdoff;
        end
        AGC_WAIT:    hold_left <= hold_left - HOLD_W'(1);
        AGC_RECOVER: gain      <= gain_up;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/agc_frame_gain.sv
module agc_frame_gain #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 4,
  parameter int CNT_W  = 8,
  parameter int HOLD_W = 8,
  localparam int STAT_W = GAIN_W + DATA_W + CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic              frame_tick,
  input  logic              cfg_enable,
  input  logic [DATA_W-1:0] cfg_target,
  input  logic [GAIN_W-1:0] cfg_attack,
  input  logic [GAIN_W-1:0] cfg_decay,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q,
  output logic              sat_flag,
  output logic [STAT_W-1:0] status_word
);
  localparam int LANES = 2;

  logic [LANES-1:0][DATA_W-1:0] lane_in, lane_out, lane_mag;
  logic [LANES-1:0]             lane_clip;
  logic [GAIN_W-1:0]            gain;
  logic [DATA_W-1:0]            smp_mag, peak_incl, frame_peak;
  logic [CNT_W-1:0]             clip_incl, frame_clips;
  logic                         accept;

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    agc_lane_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
      .din  (lane_in[l]),
      .gain (gain),
      .dout (lane_out[l]),
      .clip (lane_clip[l]),
      .mag  (lane_mag[l])
    );
  end

  assign smp_mag  = (lane_mag[0] > lane_mag[1]) ? lane_mag[0] : lane_mag[1];
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  agc_frame_stats #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_ok   (accept),
    .sample_mag  (smp_mag),
    .sample_clip (|lane_clip),
    .frame_tick  (frame_tick),
    .peak_incl   (peak_incl),
    .clip_incl   (clip_incl),
    .frame_peak  (frame_peak),
    .frame_clips (frame_clips),
    .clip_seen   (sat_flag)
  );

  agc_gain_ctrl #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .enable     (cfg_enable),
    .target     (cfg_target),
    .attack     (cfg_attack),
    .decay      (cfg_decay),
    .holdoff    (cfg_holdoff),
    .peak_incl  (peak_incl),
    .clip_incl  (clip_incl),
    .gain       (gain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_i     <= lane_out[0];
      out_q     <= lane_out[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign status_word = {cfg_enable, frame_clips, frame_peak, gain};
endmodule

// File: rtl/agc_frame_gain_chk.sv
module agc_frame_gain_chk #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 4,
  parameter int CNT_W  = 8,
  localparam int STAT_W = GAIN_W + DATA_W + CNT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              cfg_enable,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_i,
  input logic [DATA_W-1:0] out_q,
  input logic              sat_flag,
  input logic [STAT_W-1:0] status_word
);
  logic [GAIN_W-1:0]             st_gain;
  logic [DATA_W+CNT_W-1:0]       st_stats;
  assign st_gain  = status_word[GAIN_W-1:0];
  assign st_stats = status_word[STAT_W-2:GAIN_W];

  AST_GAIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    st_gain != {1'b1, {(GAIN_W-1){1'b0}}}); // R1

  AST_STATS_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(st_stats)); // R4

  AST_GAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_tick && cfg_enable) |=> $stable(st_gain)); // R8

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> !sat_flag); // R9

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q))); // R10
endmodule

bind agc_frame_gain agc_frame_gain_chk #(
  .DATA_W(DATA_W), .GAIN_W(GAIN_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_tick  (frame_tick),
  .cfg_enable  (cfg_enable),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_i       (out_i),
  .out_q       (out_q),
  .sat_flag    (sat_flag),
  .status_word (status_word)
);

// File: tb/sim_agc_frame_gain.sv
module sim_agc_frame_gain;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_i = '0, in_q = '0;
  logic        frame_tick = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [15:0] cfg_target = 16'd20000;
  logic [3:0]  cfg_attack = 4'd1, cfg_decay = 4'd2;
  logic [7:0]  cfg_holdoff = 8'd2;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_i, out_q;
  logic        sat_flag;
  logic [28:0] status_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_frame_gain u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .frame_tick(frame_tick), .cfg_enable(cfg_enable),
    .cfg_target(cfg_target), .cfg_attack(cfg_attack), .cfg_decay(cfg_decay),
    .cfg_holdoff(cfg_holdoff), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q), .sat_flag(sat_flag), .status_word(status_word)
  );

  function automatic int st_gain();  return int'($signed(status_word[3:0])); endfunction
  function automatic int st_peak();  return int'(status_word[19:4]);          endfunction
  function automatic int st_clips(); return int'(status_word[27:20]);         endfunction
  function automatic int st_en();    return int'(status_word[28]);            endfunction

  task automatic expect_val(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int i, input int q, input bit tick);
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'(i); in_q = 16'(q); frame_tick = tick;
    @(negedge clk);
    in_valid = 1'b0; frame_tick = 1'b0;
  endtask

  task automatic boundary();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic t_reset();
    expect_val("R11", "status", int'(status_word), 0);
    expect_val("R11", "out_valid", int'(out_valid), 0);
    expect_val("R11", "sat_flag", int'(sat_flag), 0);
    expect_val("R10", "in_ready idle", int'(in_ready), 1);
    expect_val("R1", "reset gain", st_gain(), 0);
  endtask

  task automatic t_unity_disabled();
    push(1234, -5, 1'b0);
    expect_val("R2", "unity i", int'($signed(out_i)), 1234);
    expect_val("R2", "unity q", int'($signed(out_q)), -5);
    expect_val("R10", "out_valid", int'(out_valid), 1);
    push(-32768, 7, 1'b0);
    expect_val("R3", "no clip at full negative", int'(sat_flag), 0);
    boundary();
    expect_val("R4", "peak of -32768", st_peak(), 32767);
    expect_val("R8", "gain held when disabled", st_gain(), 0);
    expect_val("R8", "enable bit", st_en(), 0);
  endtask

  task automatic t_recover_and_attack();
    cfg_enable = 1'b1;
    push(100, 0, 1'b0);
    boundary();
    expect_val("R7", "decay to +2", st_gain(), 2);
    expect_val("R4", "peak 100", st_peak(), 100);
    expect_val("R8", "enable bit set", st_en(), 1);
    push(-300, 0, 1'b0);
    expect_val("R2", "left shift negative", int'($signed(out_i)), -1200);
    push(20000, -20000, 1'b0);
    expect_val("R3", "clamp high", int'($signed(out_i)), 32767);
    expect_val("R3", "clamp low", int'($signed(out_q)), -32768);
    expect_val("R9", "flag after clip", int'(sat_flag), 1);
    boundary();
    expect_val("R9", "flag cleared", int'(sat_flag), 0);
    expect_val("R3", "one clip counted", st_clips(), 1);
    expect_val("R6", "attack by 1", st_gain(), 1);
  endtask

  task automatic t_holdoff();
    cfg_attack = 4'd3;
    boundary();
    expect_val("R7", "holdoff 2->1 gain held", st_gain(), 1);
    boundary();
    expect_val("R7", "holdoff 1->0 gain held", st_gain(), 1);
    boundary();
    expect_val("R7", "recover after holdoff", st_gain(), 3);
  endtask

  task automatic t_negative_gain();
    cfg_attack = 4'd7;
    push(30000, 0, 1'b0);
    boundary();
    expect_val("R6", "attack to -4", st_gain(), -4);
    push(-1000, 1000, 1'b0);
    expect_val("R2", "arith right shift neg", int'($signed(out_i)), -63);
    expect_val("R2", "right shift pos", int'($signed(out_q)), 62);
    cfg_target = 16'd1000;
    push(30000, 0, 1'b0);
    boundary();
    expect_val("R1", "floor at -7", st_gain(), -7);
    expect_val("R6", "peak above target", st_peak(), 1875);
  endtask

  task automatic t_coincident();
    cfg_target = 16'd30000;
    push(32767, 0, 1'b1);
    expect_val("R2", "shift by 7", int'($signed(out_i)), 255);
    expect_val("R5", "coincident sample in peak", st_peak(), 255);
    expect_val("R7", "holdoff blocks recovery", st_gain(), -7);
  endtask

  task automatic t_disabled_hold();
    boundary();
    cfg_enable = 1'b0;
    push(-32768, 0, 1'b0);
    expect_val("R2", "right shift full negative", int'($signed(out_i)), -256);
    boundary();
    expect_val("R8", "gain frozen", st_gain(), -7);
    expect_val("R8", "stats still captured", st_peak(), 256);
    expect_val("R8", "enable bit clear", st_en(), 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    push(32767, 0, 1'b0);
    expect_val("R10", "first result", int'($signed(out_i)), 255);
    in_valid = 1'b1; in_i = 16'h8000; in_q = '0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      expect_val("R10", "held under stall", int'($signed(out_i)), 255);
      expect_val("R10", "ready low under stall", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_val("R10", "second result", int'($signed(out_i)), -256);
    expect_val("R10", "valid after release", int'(out_valid), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unity_disabled();
    t_recover_and_attack();
    t_holdoff();
    t_negative_gain();
    t_coincident();
    t_disabled_hold();
    t_backpressure();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule